// File: doc/BRIEF.md
# Chip-Enable Write-Protect Gate

This block sits between a memory controller and a memory's active-low chip-enable pin, and blocks accesses while the supervisor holds the system in reset. With reset released and main power present, the incoming chip-enable reaches the output through logic only, with no register in the path. When reset asserts, the block samples the chip-enable level at that clock edge. An idle input is blocked at once. An access already under way may run on for a bounded number of microsecond ticks and is then cut off.

Once cut off, or once blocked, the output stays inactive (high) until the reset event ends, whatever the input does. While the supply runs from the backup battery the output is forced high at all times. When reset is released the block returns to pass-through without delay. The hold length is the parameter `HOLD_TICKS`, counted in pulses of the tick-enable input, and must be at least 1.

Top module: `ce_gate`

## Requirements
- R1: With `rst_n` high, `rst_act` low and `bkup_act` low, `ce_out_n` equals `ce_in_n` in the same cycle, and `tick_us` has no effect on it.
- R2: If `ce_in_n` is high at the clock edge where `rst_act` is first sampled high, `ce_out_n` stays high for the whole reset event, including when `ce_in_n` later goes low.
- R3: If `ce_in_n` is low at that edge, `ce_out_n` stays low while the input stays low. It goes high in the cycle after the edge that samples the `HOLD_TICKS`-th `tick_us` pulse counted after entry, and cycles without a tick do not advance the window.
- R4: If `ce_in_n` goes high during the hold window, `ce_out_n` goes high in that same cycle and stays high for the rest of the reset event, even if the input returns low.
- R5: After the hold window expires, `ce_out_n` stays high for the rest of the reset event regardless of `ce_in_n`.
- R6: While `bkup_act` is high, `ce_out_n` is high. A hold window during which `bkup_act` was seen high ends in the blocked condition.
- R7: When `rst_act` falls, `ce_out_n` follows `ce_in_n` in that same cycle, and the hold state is cleared.
- R8: While `rst_n` is low the controller is in pass-through, so `ce_out_n` equals `ce_in_n` when `rst_act` and `bkup_act` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| ce_in_n | input | 1 | Chip-enable from the memory controller, active low |
| rst_act | input | 1 | Supervisor reset asserted, active high |
| bkup_act | input | 1 | Supply running from backup battery, active high |
| tick_us | input | 1 | One-cycle pulse each microsecond |
| ce_out_n | output | 1 | Gated chip-enable to the memory, active low |

## Verification
The assertions assume that `rst_act`, `bkup_act`, `ce_in_n` and `tick_us` are synchronous to `clk` and stable around each rising edge. The hold bound also assumes `tick_us` is a single-cycle pulse. The bench drives every input on the falling edge and only ever raises the tick for one cycle at a time. It samples the output one nanosecond after driving, so the combinational path is observed before the next rising edge.

// File: rtl/ce_gate.sv
module ce_gate #(
  parameter int HOLD_TICKS = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic rst_act,
  input  logic bkup_act,
  input  logic tick_us,
  output logic ce_out_n
);
  localparam int CW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  typedef enum logic [1:0] {PASS, HOLD, BLOCK} st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    unique case (st)
      PASS: begin
        cnt_nx = '0;
        if (rst_act) st_nx = (!ce_in_n && !bkup_act) ? HOLD : BLOCK;
      end
      HOLD: begin
        if (!rst_act)                     st_nx = PASS;
        else if (ce_in_n || bkup_act)     st_nx = BLOCK;
        else if (tick_us && cnt == LAST)  st_nx = BLOCK;
        else if (tick_us)                 cnt_nx = cnt + 1'b1;
      end
      BLOCK: if (!rst_act) st_nx = PASS;
      default: st_nx = PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= PASS;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end

  assign ce_out_n = bkup_act | ce_in_n | (rst_act & (st == BLOCK));
endmodule

module ce_gate_chk #(
  parameter int HOLD_TICKS = 12
) (
  input logic clk,
  input logic rst_n,
  input logic ce_in_n,
  input logic rst_act,
  input logic bkup_act,
  input logic tick_us,
  input logic ce_out_n
);
  logic seen;
  int   low_ticks;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen      <= 1'b0;
      low_ticks <= 0;
    end else begin
      seen <= 1'b1;
      if (rst_act && !ce_out_n) low_ticks <= low_ticks + (tick_us ? 1 : 0);
      else                      low_ticks <= 0;
    end

  assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_act && !bkup_act) |-> (ce_out_n == ce_in_n));

  assert_stay_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rst_act) && $past(ce_out_n) && rst_act) |-> ce_out_n);

  assert_hold_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_ticks <= HOLD_TICKS + 1);

  assert_low_needs_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_out_n |-> !ce_in_n);

  assert_backup_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bkup_act |-> ce_out_n);
endmodule

bind ce_gate ce_gate_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .rst_act(rst_act),
  .bkup_act(bkup_act), .tick_us(tick_us), .ce_out_n(ce_out_n)
);

// File: tb/ce_gate_test.sv
`timescale 1ns/1ps
module ce_gate_test;
  localparam int HT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_in_n = 1'b1, rst_act = 1'b0, bkup_act = 1'b0, tick_us = 1'b0;
  logic ce_out_n;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ce_gate #(.HOLD_TICKS(HT)) uut (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .rst_act(rst_act),
    .bkup_act(bkup_act), .tick_us(tick_us), .ce_out_n(ce_out_n)
  );

  task automatic check(input logic exp, input string req);
    #1;
    n_chk++;
    if (ce_out_n !== exp) begin
      n_bad++;
      $display("FAIL %s: ce_out_n=%b expected %b at %0t", req, ce_out_n, exp, $time);
    end
  endtask

  task automatic step(input logic ce, input logic ra, input logic bk, input logic tk);
    @(negedge clk);
    ce_in_n = ce; rst_act = ra; bkup_act = bk; tick_us = tk;
  endtask

  task automatic release_rst();
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b1, "R7");
  endtask

  task automatic t_reset();
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check(1'b0, "R8");
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check(1'b1, "R8");
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_pass();
    step(1'b0, 1'b0, 1'b0, 1'b0); check(1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, 1'b1); check(1'b1, "R1");
    step(1'b0, 1'b0, 1'b0, 1'b1); check(1'b0, "R1");
    step(1'b0, 1'b0, 1'b0, 1'b0); check(1'b0, "R1");
    step(1'b1, 1'b0, 1'b0, 1'b0); check(1'b1, "R1");
  endtask

  task automatic t_block_high();
    step(1'b1, 1'b1, 1'b0, 1'b0); check(1'b1, "R2");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R2");
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1); check(1'b1, "R2");
    end
    step(1'b0, 1'b0, 1'b0, 1'b0); check(1'b0, "R7");
    release_rst();
  endtask

  task automatic t_hold_expire();
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R3");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R3");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R3");
    for (int i = 0; i < HT; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1); check(1'b0, "R3");
      if (i < HT - 1) begin
        step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R3");
      end
    end
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R3");
    step(1'b1, 1'b1, 1'b0, 1'b0); check(1'b1, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b1); check(1'b1, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b0); check(1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0); check(1'b0, "R7");
    release_rst();
  endtask

  task automatic t_hold_abort();
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R3");
    step(1'b1, 1'b1, 1'b0, 1'b0); check(1'b1, "R4");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R4");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R4");
    step(1'b0, 1'b0, 1'b0, 1'b0); check(1'b0, "R7");
    release_rst();
  endtask

  task automatic t_backup();
    step(1'b0, 1'b0, 1'b1, 1'b0); check(1'b1, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b0); check(1'b0, "R6");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R3");
    step(1'b0, 1'b1, 1'b1, 1'b0); check(1'b1, "R6");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b0); check(1'b0, "R7");
    release_rst();
  endtask

  task automatic t_release_in_hold();
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R3");
    step(1'b0, 1'b1, 1'b0, 1'b1); check(1'b0, "R3");
    step(1'b0, 1'b0, 1'b0, 1'b0); check(1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b0, "R7");
    for (int i = 0; i < HT - 1; i++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1); check(1'b0, "R7");
    end
    step(1'b0, 1'b1, 1'b0, 1'b1); check(1'b0, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b0); check(1'b1, "R7");
    release_rst();
  endtask

  initial begin
    t_reset();
    t_pass();
    t_block_high();
    t_hold_expire();
    t_hold_abort();
    t_backup();
    t_release_in_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule